// File: doc/BRIEF.md
# Synchronous Clock Stop Gating

This block takes one fast source clock and produces a group of gated output clocks from it: general outputs that each run at half or full rate, one dedicated output that is never stopped, and a set of differential pairs. An internal 2-bit phase counter splits time into frames of four source cycles. A half-rate output is high for the last two cycles of a frame. A full-rate output is high on every second cycle.

An active-low stop request passes through a short synchronizer and is then sampled by the half-rate phase. Only outputs that are currently half rate and not marked free-running obey the request. Each output has its own enable bit. A differential pair that is shut down parks with the true side low and the complement side high.

Every change to enable, stop or rate lands only while the affected output is low. An output therefore either shows a whole high phase or none of it, and it never shows a runt pulse. All inputs are plain level controls sampled on the source clock. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `clk_stop_gate`

## Requirements
- R1: Counting source-clock edges after reset release from 1, a running half-rate output is high after edges 4k+2 and 4k+3, and a running full-rate output is high after every odd edge.
- R2: The dedicated output always runs at half rate, obeys only its own enable and never reacts to the stop request.
- R3: The stop request is active low. It passes through two register stages, and its level at a frame-start edge (4k) decides whether stoppable half-rate outputs show the high phase that begins at edge 4k+2.
- R4: Only outputs whose rate flag is 0 (half rate) and whose free-running flag is 0 are stopped. Outputs with rate flag 1 (full rate) or free-running flag 1 keep toggling.
- R5: A cleared enable bit forces its output low whatever the stop request is. Enable changes apply only at edges where the output's own phase is low.
- R6: A rate flag (0 = half, 1 = full) written by the user takes effect only at a frame-start edge.
- R7: No output ever shows a runt. Every high pulse of a half-rate output lasts exactly two cycles, and no output stays high for more than two cycles.
- R8: A differential pair whose enable bit is 0 holds its true output low and its complement output high. A running pair toggles at full rate with the complement opposite to the true side.
- R9: While reset is held, every single-ended output and every true output is low, and every complement output is high.
- R10: After the request goes inactive, a stopped output resumes with a full-width high phase at the first sampling edge (4k+2) that sees the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Active-low stop request |
| out_en | input | N_OUT | Per-output enable |
| out_free | input | N_OUT | Per-output free-running flag, 1 = ignore stop |
| out_rate_full | input | N_OUT | Per-output rate flag, 1 = full rate |
| fixed_en | input | 1 | Enable of the dedicated never-stopped output |
| pair_en | input | N_PAIR | Per-pair enable, 0 = shut down |
| clk_out | output | N_OUT | Gated general outputs |
| fixed_clk_out | output | 1 | Dedicated half-rate output |
| pair_t | output | N_PAIR | True side of each differential pair |
| pair_c | output | N_PAIR | Complement side of each differential pair |

## Verification
Each output's run flag, rate latch and the shared phase counter are all visible at the ports within one four-cycle frame. A run flag that is out of step shows up as a whole pulse that is missing or extra. A phase slip moves the edges away from the 4k+2 and 4k+3 positions. A stale rate latch changes the pulse spacing from the next frame start. A bad stop synchronizer or hold register first appears as a half-rate pulse that is shown or withheld one frame early or late, so the bench compares every output on every cycle against a cycle-exact expectation and also measures pulse widths and pulse counts over fixed windows.

// File: rtl/clk_stop_gate_pkg.sv
package clk_stop_gate_pkg;
  localparam int PHASE_W = 2;

  typedef logic [PHASE_W-1:0] phase_t;

  // Raw (ungated) levels of the two rates for one phase value.
  typedef struct packed {
    logic half;
    logic full;
  } base_t;

  function automatic base_t phase_to_base(input phase_t p);
    base_t b;
    b.half = p[PHASE_W-1];
    b.full = p[0];
    return b;
  endfunction
endpackage

// File: rtl/cg_phase_gen.sv
module cg_phase_gen
  import clk_stop_gate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output base_t base_cur,
  output base_t base_nxt,
  output logic  frame_start,
  output logic  sample_now
);
  localparam phase_t SAMPLE_PH = phase_t'(2);

  phase_t ph_q;
  phase_t ph_d;

  assign ph_d = ph_q + phase_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign base_cur    = phase_to_base(ph_q);
  assign base_nxt    = phase_to_base(ph_d);
  assign frame_start = (ph_d == '0);
  assign sample_now  = (ph_d == SAMPLE_PH);
endmodule

// File: rtl/cg_stop_sync.sv
module cg_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req_n,
  input  logic sample_now,
  output logic stop_eff
);
  logic [STAGES-1:0] chain_q;
  logic              hold_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= stop_req_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], stop_req_n};
      end
    end
  endgenerate

  // A fresh sample is taken only at the half-rate rising edge; it is held otherwise.
  assign stop_eff = sample_now ? ~chain_q[STAGES-1] : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= stop_eff;
  end
endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell
  import clk_stop_gate_pkg::*;
#(
  parameter bit STOPPABLE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  free_run,
  input  logic  rate_full,
  input  logic  frame_start,
  input  base_t base_cur,
  input  base_t base_nxt,
  input  logic  stop_eff,
  output logic  clk_q
);
  logic rate_q, run_q;
  logic rate_upd, base_c, base_n, stop_hit, run_d;

  always_comb begin
    rate_upd = frame_start ? rate_full : rate_q;
    base_c   = rate_q   ? base_cur.full : base_cur.half;
    base_n   = rate_upd ? base_nxt.full : base_nxt.half;
    stop_hit = STOPPABLE & stop_eff & ~free_run & ~rate_q;
    // Decision may change only while this output's own phase is low.
    run_d    = base_c ? run_q : (en & ~stop_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= 1'b0;
      run_q  <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      rate_q <= rate_upd;
      run_q  <= run_d;
      clk_q  <= run_d & base_n;
    end
  end
endmodule

// File: rtl/cg_pair_cell.sv
module cg_pair_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic full_cur,
  input  logic full_nxt,
  output logic t_q,
  output logic c_q
);
  logic run_q, run_d, t_d;

  assign run_d = full_cur ? run_q : en;
  assign t_d   = run_d & full_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      t_q   <= 1'b0;
      c_q   <= 1'b1;
    end else begin
      run_q <= run_d;
      t_q   <= t_d;
      c_q   <= ~t_d;
    end
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_gate_pkg::*;
#(
  parameter int N_OUT       = 6,
  parameter int N_PAIR      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req_n,
  input  logic [N_OUT-1:0]  out_en,
  input  logic [N_OUT-1:0]  out_free,
  input  logic [N_OUT-1:0]  out_rate_full,
  input  logic              fixed_en,
  input  logic [N_PAIR-1:0] pair_en,
  output logic [N_OUT-1:0]  clk_out,
  output logic              fixed_clk_out,
  output logic [N_PAIR-1:0] pair_t,
  output logic [N_PAIR-1:0] pair_c
);
  base_t base_cur, base_nxt;
  logic  frame_start, sample_now, stop_eff;

  cg_phase_gen u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_cur    (base_cur),
    .base_nxt    (base_nxt),
    .frame_start (frame_start),
    .sample_now  (sample_now)
  );

  cg_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req_n (stop_req_n),
    .sample_now (sample_now),
    .stop_eff   (stop_eff)
  );

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      cg_gate_cell #(.STOPPABLE(1'b1)) u_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (out_en[i]),
        .free_run    (out_free[i]),
        .rate_full   (out_rate_full[i]),
        .frame_start (frame_start),
        .base_cur    (base_cur),
        .base_nxt    (base_nxt),
        .stop_eff    (stop_eff),
        .clk_q       (clk_out[i])
      );
    end

    for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
      cg_pair_cell u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pair_en[j]),
        .full_cur (base_cur.full),
        .full_nxt (base_nxt.full),
        .t_q      (pair_t[j]),
        .c_q      (pair_c[j])
      );
    end
  endgenerate

  cg_gate_cell #(.STOPPABLE(1'b0)) u_fixed (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (fixed_en),
    .free_run    (1'b1),
    .rate_full   (1'b0),
    .frame_start (frame_start),
    .base_cur    (base_cur),
    .base_nxt    (base_nxt),
    .stop_eff    (stop_eff),
    .clk_q       (fixed_clk_out)
  );
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int N_OUT  = 6,
  parameter int N_PAIR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_OUT-1:0]  clk_out,
  input logic              fixed_clk_out,
  input logic              fixed_en,
  input logic [N_PAIR-1:0] pair_en,
  input logic [N_PAIR-1:0] pair_t,
  input logic [N_PAIR-1:0] pair_c
);
  // R2: the dedicated output's low phase is always two cycles long.
  p_fixed_low_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fixed_clk_out) |=> !fixed_clk_out);

  // R7: the dedicated output's high phase is never cut short.
  p_fixed_high_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fixed_clk_out) |=> fixed_clk_out);

  // R5: four cycles of disable always park the dedicated output low.
  p_fixed_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fixed_en && !$past(fixed_en) && !$past(fixed_en, 2) && !$past(fixed_en, 3))
    |=> !fixed_clk_out);

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out_chk
      // R7: no high phase is longer than two cycles.
      p_pulse_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out[i] && $past(clk_out[i])) |=> !clk_out[i]);
    end
    for (genvar j = 0; j < N_PAIR; j++) begin : g_pair_chk
      // R8: a pair shut down for two cycles sits at true low, complement high.
      p_pair_shut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_en[j] && !$past(pair_en[j])) |=> (!pair_t[j] && pair_c[j]));
    end
  endgenerate
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_OUT(N_OUT), .N_PAIR(N_PAIR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clk_out       (clk_out),
  .fixed_clk_out (fixed_clk_out),
  .fixed_en      (fixed_en),
  .pair_en       (pair_en),
  .pair_t        (pair_t),
  .pair_c        (pair_c)
);

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_OUT  = 6;
  localparam int N_PAIR = 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n, stop_n, fen;
  logic [N_OUT-1:0]  en, fr, rt;
  logic [N_PAIR-1:0] pen;
  logic [N_OUT-1:0]  clk_out;
  logic              fixed_clk_out;
  logic [N_PAIR-1:0] pair_t, pair_c;

  clk_stop_gate #(.N_OUT(N_OUT), .N_PAIR(N_PAIR), .SYNC_STAGES(2)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_req_n    (stop_n),
    .out_en        (en),
    .out_free      (fr),
    .out_rate_full (rt),
    .fixed_en      (fen),
    .pair_en       (pen),
    .clk_out       (clk_out),
    .fixed_clk_out (fixed_clk_out),
    .pair_t        (pair_t),
    .pair_c        (pair_c)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed {
    logic [N_OUT-1:0]  co;
    logic              fx;
    logic [N_PAIR-1:0] pt;
    logic [N_PAIR-1:0] pc;
  } obs_t;

  obs_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Expected-value producer, built from the frame timing in the requirements.
  int              ph;
  bit              s1, s2, hold;
  bit [N_OUT-1:0]  m_rate, m_run;
  bit              m_frun;
  bit [N_PAIR-1:0] m_prun;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; s1 = 1; s2 = 1; hold = 0;
      m_rate = '0; m_run = '0; m_frun = 0; m_prun = '0;
      exp_q.delete();
    end else begin
      obs_t e;
      int   nph;
      bit   stop_e, cur_h, cur_f, nx_h, nx_f, fstart;
      nph    = (ph + 1) % 4;
      stop_e = (nph == 2) ? !s2 : hold;   // R3: fresh sample at edge 4k+2
      hold   = stop_e;
      s2     = s1;
      s1     = stop_n;
      fstart = (nph == 0);                // R6
      cur_h  = (ph >= 2);  cur_f = (ph % 2 == 1);
      nx_h   = (nph >= 2); nx_f  = (nph % 2 == 1);
      for (int i = 0; i < N_OUT; i++) begin
        bit old_r, new_r, own_low;
        old_r   = m_rate[i];
        new_r   = fstart ? rt[i] : old_r;
        own_low = old_r ? !cur_f : !cur_h;
        if (own_low) m_run[i] = en[i] && !(stop_e && !fr[i] && !old_r);
        e.co[i]   = m_run[i] && (new_r ? nx_f : nx_h);
        m_rate[i] = new_r;
      end
      if (!cur_h) m_frun = fen;
      e.fx = m_frun && nx_h;
      for (int j = 0; j < N_PAIR; j++) begin
        if (!cur_f) m_prun[j] = pen[j];
        e.pt[j] = m_prun[j] && nx_f;
        e.pc[j] = !e.pt[j];
      end
      ph = nph;
      exp_q.push_back(e);
    end
  end

  // Monitor: compare every cycle, count rises, measure widths.
  int   rise_cnt [N_OUT];
  int   rise_fx;
  logic [N_OUT-1:0] prev_co;
  logic prev_fx;
  int   w0, wfx;

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0) begin
        obs_t e;
        e = exp_q.pop_front();
        chk(clk_out == e.co, "R1 R3 R4 R5 R6 R10", "clk_out per-cycle",
            int'(clk_out), int'(e.co));
        chk(fixed_clk_out == e.fx, "R2", "fixed_clk_out per-cycle",
            int'(fixed_clk_out), int'(e.fx));
        chk({pair_t, pair_c} == {e.pt, e.pc}, "R8", "pair t/c per-cycle",
            int'({pair_t, pair_c}), int'({e.pt, e.pc}));
      end
      for (int i = 0; i < N_OUT; i++)
        if (clk_out[i] && !prev_co[i]) rise_cnt[i]++;
      if (fixed_clk_out && !prev_fx) rise_fx++;
      // R7: out0 stays half rate throughout; its high phases must be two cycles.
      if (clk_out[0]) w0++;
      else if (prev_co[0]) begin
        chk(w0 == 2, "R7", "out0 high width", w0, 2);
        w0 = 0;
      end
      if (fixed_clk_out) wfx++;
      else if (prev_fx) begin
        chk(wfx == 2, "R7", "fixed high width", wfx, 2);
        wfx = 0;
      end
    end else begin
      w0 = 0; wfx = 0;
    end
    prev_co = clk_out;
    prev_fx = fixed_clk_out;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < N_OUT; i++) rise_cnt[i] = 0;
    rise_fx = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    prev_co = '0; prev_fx = 0; w0 = 0; wfx = 0;
    clear_counts();
    rst_n = 0; stop_n = 1; en = '1; fr = 6'b000100; rt = 6'b001000;
    fen = 1; pen = '1;
    cycles(3);
    // R9: reset levels
    chk(clk_out == '0, "R9", "clk_out in reset", int'(clk_out), 0);
    chk(fixed_clk_out == 0, "R9", "fixed in reset", int'(fixed_clk_out), 0);
    chk(pair_t == '0, "R9", "pair_t in reset", int'(pair_t), 0);
    chk(pair_c == '1, "R9", "pair_c in reset", int'(pair_c), 3);
    rst_n = 1;
    cycles(40);
    clear_counts(); cycles(16);
    chk(rise_cnt[0] == 4, "R1", "half-rate rises in 16", rise_cnt[0], 4);
    chk(rise_cnt[3] == 8, "R1", "full-rate rises in 16", rise_cnt[3], 8);
    chk(rise_fx == 4, "R2", "fixed rises in 16", rise_fx, 4);

    // R3 R4: stop held active
    stop_n = 0;
    cycles(12); clear_counts(); cycles(16);
    chk(rise_cnt[0] + rise_cnt[1] + rise_cnt[4] + rise_cnt[5] == 0, "R3",
        "stoppable rises while stopped",
        rise_cnt[0] + rise_cnt[1] + rise_cnt[4] + rise_cnt[5], 0);
    chk(rise_cnt[2] == 4, "R4", "free-running out2 rises", rise_cnt[2], 4);
    chk(rise_cnt[3] == 8, "R4", "full-rate out3 rises", rise_cnt[3], 8);
    chk(rise_fx == 4, "R2", "fixed ignores stop", rise_fx, 4);

    // R10: release
    stop_n = 1;
    cycles(12); clear_counts(); cycles(16);
    chk(rise_cnt[0] == 4, "R10", "out0 resumed rises", rise_cnt[0], 4);

    // R5: enable cleared
    en[1] = 0;
    cycles(8); clear_counts(); cycles(16);
    chk(rise_cnt[1] == 0, "R5", "disabled out1 rises", rise_cnt[1], 0);
    en[1] = 1;

    // R6: rate change
    rt = 6'b110000;
    cycles(12); clear_counts(); cycles(16);
    chk(rise_cnt[4] == 8, "R6", "out4 now full", rise_cnt[4], 8);
    chk(rise_cnt[3] == 4, "R6", "out3 now half", rise_cnt[3], 4);
    stop_n = 0;
    cycles(12); clear_counts(); cycles(16);
    chk(rise_cnt[5] == 8, "R4", "full out5 not stopped", rise_cnt[5], 8);
    chk(rise_cnt[3] == 0, "R4", "half out3 stopped", rise_cnt[3], 0);
    stop_n = 1;

    // R8: pair shutdown
    pen = 2'b10;
    cycles(4);
    for (int k = 0; k < 6; k++) begin
      chk(pair_t[0] == 0 && pair_c[0] == 1, "R8", "pair0 parked t,c",
          int'({pair_t[0], pair_c[0]}), 1);
      cycles(1);
    end
    pen = 2'b11;

    // R5: dedicated output disable
    fen = 0;
    cycles(8); clear_counts(); cycles(16);
    chk(rise_fx == 0, "R5", "fixed disabled rises", rise_fx, 0);
    fen = 1;

    // Mixed stimulus; out0 keeps half rate and enable.
    lfsr = 16'hACE1;
    for (int k = 0; k < 800; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) stop_n = ~stop_n;
      if (lfsr[6:3] == 4'd1) en[5:1] = lfsr[15:11];
      if (lfsr[6:3] == 4'd2) fr = lfsr[13:8];
      if (lfsr[6:3] == 4'd3) rt[5:1] = lfsr[12:8];
      if (lfsr[6:3] == 4'd4) pen = lfsr[9:8];
      if (lfsr[6:3] == 4'd5) fen = lfsr[10];
      cycles(1);
    end
    cycles(4);
    finish_run();
  end
endmodule